// File: doc/BRIEF.md
# Fully Associative Multi-Size Translation Buffer

This block translates 32-bit effective addresses to real addresses through a fully associative set of translation entries. Each entry has its own page size: 4K, 16K, 512K or 8M. Each entry also has four 1K subpage enable flags, an address space tag, a shared attribute and a privilege tag. A lookup presents an effective address together with the current privilege state, the current address space tag and a translation enable. One clock later the block returns a hit flag, the index of the matching entry and the real address. With translation disabled, the address passes through untouched.

Software fills entries through a reload port, and the reload index comes from software. On a reload, the entry at that index is overwritten. In the same cycle, every other valid entry that could answer the same lookup as the new entry is dropped, so two entries never answer one lookup. A flush input empties the whole buffer in one cycle.

The lookup path is a stream without back-pressure. A request is accepted in every cycle in which `lu_valid` is high. Its result appears with `res_valid` one cycle later, and it must be taken in that cycle because nothing holds it. The reload and flush pins are plain controls that act on the clock edge.

Top module: `multi_size_tlb`

## Requirements
- R1: While `xlat_en` is low, an accepted lookup returns `res_hit`=1, `res_idx`=0 and `res_pa` equal to `lu_ea`.
- R2: `wr_size` encodes the page size: 00 is 4K, 01 is 16K, 10 is 512K and 11 is 8M. Address bits from the page size upward are compared with the stored page number. Bits below the page size pass straight to the real address.
- R3: Flag bit k of `wr_sub` enables the 1K subpage selected by `lu_ea[11:10]`=k. A lookup whose subpage flag is clear misses.
- R4: A nonshared entry (`wr_shared`=0) hits only when `lu_asid` equals its stored tag. A shared entry ignores `lu_asid`.
- R5: On a hit, `res_pa` is the stored real page number, with the bits below the page size cleared, placed above the untranslated low address bits. On a miss, `res_hit`=0, `res_idx`=0 and `res_pa`=0.
- R6: A reload writes a valid entry at `wr_idx`. In the same cycle it invalidates every other valid entry that overlaps the new one. Two entries overlap when all of the following hold: their page ranges intersect at the larger of the two sizes, their subpage flags share a set bit, their privilege tags are equal, and either one is shared or their address space tags are equal.
- R7: `res_valid` in a cycle equals `lu_valid` of the previous cycle. The result fields belong to that request.
- R8: A lookup in the same cycle as a reload or a flush sees the buffer contents from before that edge.
- R9: `inv_all` invalidates every entry in one cycle. It takes priority over a reload in the same cycle.
- R10: At most one entry matches any lookup.
- R11: An entry hits only when `lu_priv` equals its stored privilege tag.
- R12: After reset, `res_valid` is 0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | Lookup request present |
| lu_ea | input | 32 | Effective address |
| lu_priv | input | 1 | Current privilege state |
| lu_asid | input | 4 | Current address space tag |
| xlat_en | input | 1 | Translation enable; low passes the address through |
| res_valid | output | 1 | Result of last cycle's request |
| res_hit | output | 1 | Translation found, or bypass |
| res_idx | output | 5 | Index of the matching entry |
| res_pa | output | 32 | Real address |
| wr_en | input | 1 | Reload one entry |
| wr_idx | input | 5 | Entry to overwrite |
| wr_epn | input | 20 | Effective page number (address bits 31:12) |
| wr_rpn | input | 20 | Real page number (address bits 31:12) |
| wr_size | input | 2 | Page size code |
| wr_sub | input | 4 | 1K subpage enable flags |
| wr_shared | input | 1 | Entry ignores address space tag |
| wr_asid | input | 4 | Address space tag of the entry |
| wr_priv | input | 1 | Privilege tag of the entry |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The hardest case to reach is a reload that overlaps a live entry of a different page size, with the overlap decided only by subpage flags, privilege or the address space tags. Overlaps between large and small pages almost never happen with uniform addresses. The random stimulus therefore draws page numbers from a narrow window at the bottom of the address space, so 8M and 512K pages cover many 4K and 16K entries. It uses only four address space tags and mixes shared and private entries. It also derives most lookup addresses from live entries of a bench model, so hits, subpage misses and tag misses all occur often. Directed steps add a lookup in the same cycle as the reload that replaces its target.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int EA_W   = 32;
  parameter int OFS_W  = 12;
  parameter int PG_W   = EA_W - OFS_W;
  parameter int ASID_W = 4;
  parameter int SUB_N  = 4;

  typedef enum logic [1:0] {PG_4K = 2'b00, PG_16K = 2'b01, PG_512K = 2'b10, PG_8M = 2'b11} pg_size_e;

  typedef struct packed {
    logic [PG_W-1:0]   epn;
    logic [PG_W-1:0]   rpn;
    pg_size_e          size;
    logic [SUB_N-1:0]  sub;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic              priv;
  } tlb_ent_t;

  // page-number bits that take part in the comparison for a given size
  function automatic logic [PG_W-1:0] pn_mask(pg_size_e s);
    case (s)
      PG_4K:   pn_mask = {PG_W{1'b1}};
      PG_16K:  pn_mask = {PG_W{1'b1}} << 2;
      PG_512K: pn_mask = {PG_W{1'b1}} << 7;
      default: pn_mask = {PG_W{1'b1}} << 11;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              wr_en,
  input  logic              wr_me,
  input  tlb_ent_t          wr_ent,
  input  logic [EA_W-1:0]   lu_ea,
  input  logic              lu_priv,
  input  logic [ASID_W-1:0] lu_asid,
  output logic              match,
  output logic [EA_W-1:0]   pa,
  output logic              vld
);
  tlb_ent_t ent;
  tlb_ent_t wr_clean;
  logic     overlap;
  logic [PG_W-1:0] ovl_mask;
  logic [PG_W-1:0] own_mask;

  always_comb begin
    wr_clean     = wr_ent;
    wr_clean.epn = wr_ent.epn & pn_mask(wr_ent.size);
    wr_clean.rpn = wr_ent.rpn & pn_mask(wr_ent.size);
  end

  // could the stored entry and the incoming one answer the same lookup?
  always_comb begin
    ovl_mask = pn_mask(wr_ent.size) & pn_mask(ent.size);
    overlap  = vld
             && ((wr_ent.epn & ovl_mask) == (ent.epn & ovl_mask))
             && (|(wr_ent.sub & ent.sub))
             && (wr_ent.priv == ent.priv)
             && (wr_ent.shared || ent.shared || (wr_ent.asid == ent.asid));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      ent <= '0;
    end else if (inv_all) begin
      vld <= 1'b0;
    end else if (wr_en && wr_me) begin
      vld <= 1'b1;
      ent <= wr_clean;
    end else if (wr_en && overlap) begin
      vld <= 1'b0;
    end
  end

  always_comb begin
    own_mask = pn_mask(ent.size);
    match = vld
          && ((lu_ea[EA_W-1:OFS_W] & own_mask) == ent.epn)
          && ent.sub[lu_ea[OFS_W-1:OFS_W-2]]
          && (lu_priv == ent.priv)
          && (ent.shared || (ent.asid == lu_asid));
    pa = {ent.rpn, {OFS_W{1'b0}}} | (lu_ea & ~{own_mask, {OFS_W{1'b0}}});
  end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel
  import tlb_pkg::*;
#(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    match,
  input  logic [EA_W-1:0] pa_in [N],
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [EA_W-1:0] pa
);
  // match is one-hot or empty, so OR-combining selects the single winner
  always_comb begin
    hit = |match;
    idx = '0;
    pa  = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        idx = idx | IW'(i);
        pa  = pa | pa_in[i];
      end
    end
  end
endmodule

// File: rtl/multi_size_tlb.sv
module multi_size_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lu_valid,
  input  logic [EA_W-1:0]   lu_ea,
  input  logic              lu_priv,
  input  logic [ASID_W-1:0] lu_asid,
  input  logic              xlat_en,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [EA_W-1:0]   res_pa,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PG_W-1:0]   wr_epn,
  input  logic [PG_W-1:0]   wr_rpn,
  input  logic [1:0]        wr_size,
  input  logic [SUB_N-1:0]  wr_sub,
  input  logic              wr_shared,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_priv,
  input  logic              inv_all
);
  tlb_ent_t         wr_ent;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [EA_W-1:0]  pa_vec [ENTRIES];
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [EA_W-1:0]  hit_pa;

  always_comb begin
    wr_ent.epn    = wr_epn;
    wr_ent.rpn    = wr_rpn;
    wr_ent.size   = pg_size_e'(wr_size);
    wr_ent.sub    = wr_sub;
    wr_ent.shared = wr_shared;
    wr_ent.asid   = wr_asid;
    wr_ent.priv   = wr_priv;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .inv_all (inv_all),
      .wr_en   (wr_en),
      .wr_me   (wr_idx == IDX_W'(g)),
      .wr_ent  (wr_ent),
      .lu_ea   (lu_ea),
      .lu_priv (lu_priv),
      .lu_asid (lu_asid),
      .match   (match_vec[g]),
      .pa      (pa_vec[g]),
      .vld     (valid_vec[g])
    );
  end

  tlb_hit_sel #(.N(ENTRIES)) u_sel (
    .match (match_vec),
    .pa_in (pa_vec),
    .hit   (any_hit),
    .idx   (hit_idx),
    .pa    (hit_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_pa    <= '0;
    end else begin
      res_valid <= lu_valid;
      if (!xlat_en) begin
        res_hit <= 1'b1;
        res_idx <= '0;
        res_pa  <= lu_ea;
      end else begin
        res_hit <= any_hit;
        res_idx <= hit_idx;
        res_pa  <= hit_pa;
      end
    end
  end
endmodule

// File: rtl/multi_size_tlb_chk.sv
module multi_size_tlb_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lu_valid,
  input logic [EA_W-1:0]    lu_ea,
  input logic               xlat_en,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [EA_W-1:0]    res_pa,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               inv_all,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_valid && !xlat_en) |=> (res_hit && res_idx == '0 && res_pa == $past(lu_ea)));

  p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lu_valid |=> (!res_hit || res_pa[9:0] == $past(lu_ea[9:0])));

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_pa == '0 && res_idx == '0));

  p_reload_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all) |=> valid_vec[$past(wr_idx)]);

  p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_valid == $past(lu_valid)));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

bind multi_size_tlb multi_size_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lu_valid  (lu_valid),
  .lu_ea     (lu_ea),
  .xlat_en   (xlat_en),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .res_pa    (res_pa),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .inv_all   (inv_all),
  .match_vec (match_vec),
  .valid_vec (valid_vec)
);

// File: tb/multi_size_tlb_test.sv
module multi_size_tlb_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, lu_valid, lu_priv, xlat_en, res_valid, res_hit;
  logic wr_en, wr_shared, wr_priv, inv_all;
  logic [31:0] lu_ea, res_pa;
  logic [3:0]  lu_asid, wr_sub, wr_asid;
  logic [4:0]  res_idx, wr_idx;
  logic [19:0] wr_epn, wr_rpn;
  logic [1:0]  wr_size;

  multi_size_tlb uut (.*);

  typedef struct {
    bit v; bit [19:0] epn; bit [19:0] rpn; bit [1:0] sz;
    bit [3:0] sub; bit sh; bit [3:0] asid; bit pr;
  } ment_t;
  ment_t m [32];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic bit [19:0] fmask(bit [1:0] s);
    case (s)
      2'd0: return 20'hFFFFF;
      2'd1: return 20'hFFFFC;
      2'd2: return 20'hFFF80;
      default: return 20'hFF800;
    endcase
  endfunction

  function automatic bit fhit(int i, bit [31:0] ea, bit pr, bit [3:0] as);
    return m[i].v && ((ea[31:12] & fmask(m[i].sz)) == (m[i].epn & fmask(m[i].sz)))
        && m[i].sub[ea[11:10]] && (pr == m[i].pr) && (m[i].sh || as == m[i].asid);
  endfunction

  function automatic bit fovl(int j);
    bit [19:0] k = fmask(wr_size) & fmask(m[j].sz);
    return m[j].v && ((wr_epn & k) == (m[j].epn & k)) && ((wr_sub & m[j].sub) != 0)
        && (wr_priv == m[j].pr) && (wr_shared || m[j].sh || wr_asid == m[j].asid);
  endfunction

  task automatic chk(string req, bit [63:0] act, bit [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: expected from model state before the edge, then model update
  task automatic step(string req);
    bit eh = 0; bit [4:0] ei = 0; bit [31:0] ep = 0; int nm = 0;
    bit lv = lu_valid;
    if (!xlat_en) begin eh = 1; ep = lu_ea; end
    else for (int i = 0; i < 32; i++) if (fhit(i, lu_ea, lu_priv, lu_asid)) begin
      nm++; eh = 1; ei = 5'(i);
      ep = {m[i].rpn & fmask(m[i].sz), 12'h0} | (lu_ea & ~{fmask(m[i].sz), 12'h0});
    end
    @(posedge clk); #1;
    chk({req, " R7 valid"}, 64'(res_valid), 64'(lv));
    if (lv) chk(req, {res_hit, res_idx, res_pa}, {eh, ei, ep});
    chk("R10 single match in model", 64'(nm > 1), 64'(0));
    if (inv_all) begin
      for (int j = 0; j < 32; j++) m[j].v = 0;
    end else if (wr_en) begin
      for (int j = 0; j < 32; j++) if (j != int'(wr_idx) && fovl(j)) m[j].v = 0;
      m[wr_idx] = '{1, wr_epn, wr_rpn, wr_size, wr_sub, wr_shared, wr_asid, wr_priv};
    end
    @(negedge clk);
    lu_valid = 0; wr_en = 0; inv_all = 0; xlat_en = 1;
  endtask

  task automatic look(bit [31:0] ea, bit pr, bit [3:0] as);
    lu_valid = 1; lu_ea = ea; lu_priv = pr; lu_asid = as;
  endtask

  task automatic load(bit [4:0] i, bit [19:0] e, bit [19:0] r, bit [1:0] s,
                      bit [3:0] sb, bit sh, bit [3:0] as, bit pr);
    wr_en = 1; wr_idx = i; wr_epn = e; wr_rpn = r; wr_size = s;
    wr_sub = sb; wr_shared = sh; wr_asid = as; wr_priv = pr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    for (int j = 0; j < 32; j++) m[j] = '{0, 0, 0, 0, 0, 0, 0, 0};
    rst_n = 0; lu_valid = 0; lu_ea = 0; lu_priv = 0; lu_asid = 0; xlat_en = 1;
    wr_en = 0; wr_idx = 0; wr_epn = 0; wr_rpn = 0; wr_size = 0; wr_sub = 0;
    wr_shared = 0; wr_asid = 0; wr_priv = 0; inv_all = 0;
    repeat (3) @(posedge clk);
    #1 chk("R12 reset res_valid", 64'(res_valid), 64'(0));
    @(negedge clk); rst_n = 1;
    look(32'h0001_0000, 0, 0); step("R12 empty after reset");
    look(32'hDEAD_BEEF, 1, 9); xlat_en = 0; step("R1 bypass");
    step("R7 idle");
    // 4K page with subpages 0 and 2 enabled
    load(1, 20'h00010, 20'hABCDE, 2'b00, 4'b0101, 0, 3, 0); step("R6 reload");
    look(32'h0001_0123, 0, 3); step("R5 4K hit subpage 0");
    look(32'h0001_0923, 0, 3); step("R3 subpage 2 enabled");
    look(32'h0001_0523, 0, 3); step("R3 subpage 1 disabled");
    look(32'h0001_0123, 0, 2); step("R4 private asid mismatch");
    look(32'h0001_0123, 1, 3); step("R11 privilege mismatch");
    // shared 8M page, real page number masked
    load(2, 20'h00800, 20'h12345, 2'b11, 4'hF, 1, 0, 0); step("R6 reload 8M");
    look(32'h00AB_CDEF, 0, 9); step("R2 8M hit any asid");
    look(32'h00AB_CDEF, 0, 4); step("R4 shared ignores asid");
    // 16K private inside the 8M range: overlaps via shared
    load(5, 20'h00808, 20'h55555, 2'b01, 4'hF, 0, 7, 0); step("R6 overlap reload");
    look(32'h00AB_CDEF, 0, 9); step("R6 8M entry dropped");
    look(32'h0080_B123, 0, 7); step("R2 16K hit");
    // different privilege: no overlap
    load(6, 20'h00808, 20'h77777, 2'b10, 4'hF, 0, 7, 1); step("R6 no overlap other priv");
    look(32'h0080_B123, 0, 7); step("R6 16K survives");
    look(32'h0087_F000, 1, 7); step("R2 512K hit");
    // lookup in the same cycle as the reload that replaces its target
    look(32'h0080_B123, 0, 7); load(5, 20'h00300, 20'h00001, 2'b00, 4'hF, 0, 7, 0);
    step("R8 old state on reload");
    look(32'h0080_B123, 0, 7); step("R8 new state after reload");
    look(32'h0001_0123, 0, 3); inv_all = 1; load(9, 20'h00010, 20'h1, 2'b00, 4'hF, 1, 0, 0);
    step("R8 old state on flush");
    look(32'h0001_0123, 0, 3); step("R9 flush beat reload");
    look(32'h0087_F000, 1, 7); step("R9 all gone");
    // constrained random
    for (int t = 0; t < 4000; t++) begin
      int pick = $urandom_range(0, 31);
      if ($urandom_range(0, 9) < 3) begin
        bit [1:0] s = 2'($urandom_range(0, 3));
        bit [3:0] sb = (s == 0) ? 4'($urandom) : ($urandom_range(0, 7) != 0 ? 4'hF : 4'h0);
        load(5'($urandom), 20'($urandom_range(0, 63)) << $urandom_range(0, 12), 20'($urandom),
             s, sb, $urandom_range(0, 3) == 0, 4'($urandom_range(0, 3)), 1'($urandom));
      end
      inv_all = ($urandom_range(0, 299) == 0);
      xlat_en = ($urandom_range(0, 9) != 0);
      lu_valid = ($urandom_range(0, 4) != 0);
      if (m[pick].v && $urandom_range(0, 3) != 0) begin
        lu_ea = ({m[pick].epn, 12'h0} & {fmask(m[pick].sz), 12'h0}) |
                ($urandom & ~{fmask(m[pick].sz), 12'h0});
        lu_priv = ($urandom_range(0, 7) == 0) ? ~m[pick].pr : m[pick].pr;
        lu_asid = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 3)) : m[pick].asid;
      end else begin
        lu_ea = $urandom & 32'h03FF_FFFF; lu_priv = 1'($urandom);
        lu_asid = 4'($urandom_range(0, 3));
      end
      step("R5 random lookup");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule